// File: doc/BRIEF.md
# Bank-Switching Address Translator

This block widens a 16-bit logical address into a 20-bit physical address, so that a processor with a 64 KB address reach can use up to 1 MB of memory. The logical space is split into three consecutive areas. The lowest area, the root area, is never relocated. Above it sits a bank area that software can move around physical memory. The top area, the common area, has a physical base of its own. Both area starts are programmable in 4 KB steps.

Software programs three 8-bit registers through a simple write port. The first holds the two area boundaries. The second holds the physical base of the common area. The third holds the physical base of the bank area. Each base counts in 4 KB units. For each request, the unit compares the top nibble of the logical address against both boundaries, picks an area, and adds the chosen base shifted up by 12 bits. It returns the physical address and the area code one cycle later.

Changing a base register moves the whole bank or common window to another place in physical memory, with no change to code or data. With the reset settings, the 64 KB logical space maps one-to-one onto the lowest 64 KB of physical memory.

Top module: `area_remap`

## Requirements
- R1: After reset, the boundary register holds 0xF0 and both base registers hold 0. `rsp_vld` is 0, `rsp_paddr` is 0 and `rsp_area` is 0. Any logical address then translates to the same value, zero-extended.
- R2: Let N be the top nibble of the logical address. When N is at or above the common start, `rsp_area` is 2 (common). Otherwise, when N is at or above the bank start, it is 1 (bank). Otherwise it is 0 (root). The value 3 is never produced.
- R3: In the root area, `rsp_paddr` is the logical address zero-extended to 20 bits.
- R4: In the bank area, `rsp_paddr` is the logical address plus the bank base shifted left by 12. The low 12 bits of the logical address pass through unchanged.
- R5: In the common area, `rsp_paddr` is the logical address plus the common base shifted left by 12.
- R6: The sum wraps modulo 2^20. There is no carry out.
- R7: `rsp_vld` equals `req_vld` of the previous cycle. `rsp_paddr` and `rsp_area` then belong to the request presented in that previous cycle.
- R8: In a cycle with `req_vld` low, `rsp_paddr` and `rsp_area` keep their values into the next cycle.
- R9: A write with `cfg_we` high loads the register picked by `cfg_sel`. Code 0 selects the boundary register: bits 7:4 hold the common start and bits 3:0 hold the bank start, both in 4 KB units. Code 1 selects the common base and code 2 selects the bank base. Code 3 writes nothing.
- R10: A register write becomes visible to requests from the cycle after the write. A request in the same cycle as the write is translated with the old value.
- R11: When the bank start is at or above the common start, no address falls in the bank area. Addresses below the common start are root, and the rest are common.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 boundaries, 1 common base, 2 bank base, 3 none |
| cfg_wdata | input | 8 | Register write data |
| req_vld | input | 1 | Translation request valid |
| req_laddr | input | 16 | Logical address |
| rsp_vld | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 20 | Translated physical address |
| rsp_area | output | 2 | Area of the translated address: 0 root, 1 bank, 2 common |

## Verification
The assertions assume that `rst_n` is released in step with the clock. They also assume that `req_vld`, `req_laddr` and the write port carry known values at every rising edge once out of reset. Only then do the hold and latency properties tie each response to one defined request. The bench starts every input at zero before the first edge and changes inputs only on falling edges. This keeps each request and write stable across the rising edge that samples it, including the case where a write and a request share one edge.

// File: rtl/area_remap_pkg.sv
package area_remap_pkg;

  // Area codes driven on rsp_area
  typedef enum logic [1:0] {
    AREA_ROOT   = 2'd0,
    AREA_BANK   = 2'd1,
    AREA_COMMON = 2'd2
  } area_e;

  // Register select codes on cfg_sel
  typedef enum logic [1:0] {
    CSEL_BOUND = 2'd0,
    CSEL_CBASE = 2'd1,
    CSEL_BBASE = 2'd2,
    CSEL_NONE  = 2'd3
  } csel_e;

  // Relocatable areas with a base register: index 0 common, 1 bank
  localparam int unsigned NUM_BASES  = 2;
  localparam int unsigned BASE_IDX_C = 0;
  localparam int unsigned BASE_IDX_B = 1;

endpackage

// File: rtl/area_remap_cfg.sv
module area_remap_cfg
  import area_remap_pkg::*;
#(
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned BASE_W    = 8,
  parameter int unsigned RST_BOUND = 'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [BASE_W-1:0] cfg_wdata,
  output logic [NIB_W-1:0]  bound_common,
  output logic [NIB_W-1:0]  bound_bank,
  output logic [BASE_W-1:0] base_common,
  output logic [BASE_W-1:0] base_bank
);

  localparam int unsigned BND_W = 2 * NIB_W;

  csel_e sel_e;
  assign sel_e = csel_e'(cfg_sel);

  // Boundary register: upper field common start, lower field bank start
  logic             bnd_en;
  logic [BND_W-1:0] bnd_d;
  logic [BND_W-1:0] bnd_q;

  always_comb begin
    bnd_en = cfg_we && (sel_e == CSEL_BOUND);
    bnd_d  = cfg_wdata[BND_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q <= BND_W'(RST_BOUND);
    end else if (bnd_en) begin
      bnd_q <= bnd_d;
    end
  end

  assign bound_common = bnd_q[BND_W-1:NIB_W];
  assign bound_bank   = bnd_q[NIB_W-1:0];

  // Base registers, one per relocatable area; select code is index + 1
  logic [NUM_BASES-1:0][BASE_W-1:0] base_all;

  for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
    logic              en;
    logic [BASE_W-1:0] d;
    logic [BASE_W-1:0] q;

    always_comb begin
      en = cfg_we && (cfg_sel == 2'(g + 1));
      d  = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign base_all[g] = q;
  end

  assign base_common = base_all[BASE_IDX_C];
  assign base_bank   = base_all[BASE_IDX_B];

endmodule

// File: rtl/area_remap_sel.sv
module area_remap_sel
  import area_remap_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic [NIB_W-1:0] laddr_top,
  input  logic [NIB_W-1:0] bound_common,
  input  logic [NIB_W-1:0] bound_bank,
  output logic [1:0]       area
);

  logic  in_common;
  logic  in_bank;
  area_e area_e_w;

  // Common start has priority over bank start
  always_comb begin
    in_common = (laddr_top >= bound_common);
    in_bank   = (laddr_top >= bound_bank);
    if (in_common) begin
      area_e_w = AREA_COMMON;
    end else if (in_bank) begin
      area_e_w = AREA_BANK;
    end else begin
      area_e_w = AREA_ROOT;
    end
  end

  assign area = area_e_w;

endmodule

// File: rtl/area_remap_add.sv
module area_remap_add
  import area_remap_pkg::*;
#(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PADDR_W = 20,
  parameter int unsigned BASE_W  = 8
) (
  input  logic [LADDR_W-1:0] laddr,
  input  logic [1:0]         area,
  input  logic [BASE_W-1:0]  base_common,
  input  logic [BASE_W-1:0]  base_bank,
  output logic [PADDR_W-1:0] paddr
);

  localparam int unsigned SHIFT = PADDR_W - BASE_W;
  localparam int unsigned EXT_W = PADDR_W - LADDR_W;

  logic [BASE_W-1:0]  base_sel;
  logic [PADDR_W-1:0] offset;
  logic [PADDR_W-1:0] laddr_ext;

  always_comb begin
    case (area_e'(area))
      AREA_COMMON: base_sel = base_common;
      AREA_BANK:   base_sel = base_bank;
      default:     base_sel = '0;
    endcase
    offset    = {base_sel, {SHIFT{1'b0}}};
    laddr_ext = {{EXT_W{1'b0}}, laddr};
    // Carry out of the top bit is dropped: modulo 2^PADDR_W
    paddr     = laddr_ext + offset;
  end

endmodule

// File: rtl/area_remap.sv
module area_remap
  import area_remap_pkg::*;
#(
  parameter int unsigned LADDR_W   = 16,
  parameter int unsigned PADDR_W   = 20,
  parameter int unsigned BASE_W    = 8,
  parameter int unsigned RST_BOUND = 'hF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [BASE_W-1:0]  cfg_wdata,
  input  logic               req_vld,
  input  logic [LADDR_W-1:0] req_laddr,
  output logic               rsp_vld,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic [1:0]         rsp_area
);

  localparam int unsigned SHIFT = PADDR_W - BASE_W;
  localparam int unsigned NIB_W = LADDR_W - SHIFT;

  logic [NIB_W-1:0]   bound_common;
  logic [NIB_W-1:0]   bound_bank;
  logic [BASE_W-1:0]  base_common;
  logic [BASE_W-1:0]  base_bank;
  logic [1:0]         area_w;
  logic [PADDR_W-1:0] paddr_w;

  area_remap_cfg #(
    .NIB_W     (NIB_W),
    .BASE_W    (BASE_W),
    .RST_BOUND (RST_BOUND)
  ) i_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .bound_common (bound_common),
    .bound_bank   (bound_bank),
    .base_common  (base_common),
    .base_bank    (base_bank)
  );

  area_remap_sel #(
    .NIB_W (NIB_W)
  ) i_sel (
    .laddr_top    (req_laddr[LADDR_W-1:SHIFT]),
    .bound_common (bound_common),
    .bound_bank   (bound_bank),
    .area         (area_w)
  );

  area_remap_add #(
    .LADDR_W (LADDR_W),
    .PADDR_W (PADDR_W),
    .BASE_W  (BASE_W)
  ) i_add (
    .laddr       (req_laddr),
    .area        (area_w),
    .base_common (base_common),
    .base_bank   (base_bank),
    .paddr       (paddr_w)
  );

  // Response stage: valid always follows, payload loads only on a request
  logic               vld_d;
  logic               vld_q;
  logic               pay_en;
  logic [PADDR_W-1:0] paddr_d;
  logic [PADDR_W-1:0] paddr_q;
  logic [1:0]         area_d;
  logic [1:0]         area_q;

  always_comb begin
    vld_d   = req_vld;
    pay_en  = req_vld;
    paddr_d = paddr_w;
    area_d  = area_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      area_q  <= AREA_ROOT;
    end else if (pay_en) begin
      paddr_q <= paddr_d;
      area_q  <= area_d;
    end
  end

  assign rsp_vld   = vld_q;
  assign rsp_paddr = paddr_q;
  assign rsp_area  = area_q;

endmodule

// File: rtl/area_remap_chk.sv
module area_remap_chk #(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PADDR_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_vld,
  input logic [LADDR_W-1:0] req_laddr,
  input logic               rsp_vld,
  input logic [PADDR_W-1:0] rsp_paddr,
  input logic [1:0]         rsp_area
);

  // R7: a request produces a valid response on the next edge
  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  // R7: no request, no valid response on the next edge
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);

  // R8: payload holds when no request is presented
  assert_hold_payload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(rsp_paddr) && $stable(rsp_area)));

  // R2: the unused area code never appears
  assert_area_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_area != 2'd3);

  // R3: root results stay inside the logical reach
  assert_root_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_area == 2'd0) |-> (rsp_paddr[PADDR_W-1:LADDR_W] == '0));

  // R4: the in-page offset passes through untouched in every area
  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (rsp_paddr[11:0] == $past(req_laddr[11:0])));

endmodule

bind area_remap area_remap_chk #(
  .LADDR_W (LADDR_W),
  .PADDR_W (PADDR_W)
) i_area_remap_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_laddr (req_laddr),
  .rsp_vld   (rsp_vld),
  .rsp_paddr (rsp_paddr),
  .rsp_area  (rsp_area)
);

// File: tb/test_area_remap.sv
module test_area_remap;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        req_vld;
  logic [15:0] req_laddr;
  logic        rsp_vld;
  logic [19:0] rsp_paddr;
  logic [1:0]  rsp_area;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  area_remap i_area_remap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .req_vld   (req_vld),
    .req_laddr (req_laddr),
    .rsp_vld   (rsp_vld),
    .rsp_paddr (rsp_paddr),
    .rsp_area  (rsp_area)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {boundaries, common base, bank base, logical addr, expected paddr, expected area}
  localparam int NV = 14;
  localparam logic [61:0] VEC [NV] = '{
    {8'hF0, 8'h00, 8'h00, 16'h1234, 20'h01234, 2'd1},
    {8'hE2, 8'h30, 8'h10, 16'h1FFF, 20'h01FFF, 2'd0},
    {8'hE2, 8'h30, 8'h10, 16'h2000, 20'h12000, 2'd1},
    {8'hE2, 8'h30, 8'h10, 16'hDFFF, 20'h1DFFF, 2'd1},
    {8'hE2, 8'h30, 8'h10, 16'hE000, 20'h3E000, 2'd2},
    {8'hE2, 8'h30, 8'h10, 16'hFFFF, 20'h3FFFF, 2'd2},
    {8'hE2, 8'hFF, 8'h10, 16'hF123, 20'h0E123, 2'd2},  // R6 wrap
    {8'hE2, 8'h30, 8'hF8, 16'h5ABC, 20'hFDABC, 2'd1},
    {8'h44, 8'h50, 8'h60, 16'h4000, 20'h54000, 2'd2},  // R11 equal starts
    {8'h48, 8'h50, 8'h60, 16'h7FFF, 20'h57FFF, 2'd2},  // R11 bank above common
    {8'h48, 8'h50, 8'h60, 16'h3FFF, 20'h03FFF, 2'd0},
    {8'h00, 8'h77, 8'h66, 16'h0000, 20'h77000, 2'd2},
    {8'h8F, 8'h50, 8'h60, 16'h7FFF, 20'h07FFF, 2'd0},
    {8'h31, 8'hA0, 8'h04, 16'h1000, 20'h05000, 2'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Presents one request; returns at the falling edge after the capturing edge
  task automatic xlate(input logic [15:0] a);
    @(negedge clk);
    req_vld = 1'b1; req_laddr = a;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  function automatic string area_tag(input logic [1:0] a);
    if (a == 2'd0) return "R3 root paddr";
    if (a == 2'd1) return "R4 bank paddr";
    return "R5 common paddr";
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'h00;
    req_vld = 1'b0; req_laddr = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of outputs
    check("R1 rsp_vld", 32'(rsp_vld), 32'd0);
    check("R1 rsp_paddr", 32'(rsp_paddr), 32'd0);
    check("R1 rsp_area", 32'(rsp_area), 32'd0);

    // R1: identity mapping with reset registers
    xlate(16'hABCD);
    check("R1 identity paddr", 32'(rsp_paddr), 32'h0ABCD);
    check("R1 area below F", 32'(rsp_area), 32'd1);
    xlate(16'hFFFF);
    check("R1 identity top", 32'(rsp_paddr), 32'h0FFFF);
    check("R1 common at F", 32'(rsp_area), 32'd2);

    // Vector table: R2 area choice with R3/R4/R5 sums
    for (int i = 0; i < NV; i++) begin
      logic [61:0] v;
      v = VEC[i];
      cfg_write(2'd0, v[61:54]);
      cfg_write(2'd1, v[53:46]);
      cfg_write(2'd2, v[45:38]);
      xlate(v[37:22]);
      check(area_tag(v[1:0]), 32'(rsp_paddr), 32'(v[21:2]));
      check("R2 area", 32'(rsp_area), 32'(v[1:0]));
      check("R7 valid", 32'(rsp_vld), 32'd1);
    end

    // R6: wrap past the top of physical space from the bank area
    cfg_write(2'd0, 8'hE2);
    cfg_write(2'd1, 8'h30);
    cfg_write(2'd2, 8'hFE);
    xlate(16'h3456);
    check("R6 wrap bank", 32'(rsp_paddr), 32'h01456);

    // R11: bank start above common start leaves no bank area
    cfg_write(2'd0, 8'h6A);
    xlate(16'h5FFF);
    check("R11 below common", 32'(rsp_area), 32'd0);
    xlate(16'hB000);
    check("R11 above both", 32'(rsp_area), 32'd2);

    // R9: select code 3 must change nothing
    cfg_write(2'd0, 8'hE2);
    cfg_write(2'd1, 8'h30);
    cfg_write(2'd2, 8'h10);
    cfg_write(2'd3, 8'h55);
    xlate(16'h2000);
    check("R9 bank base kept", 32'(rsp_paddr), 32'h12000);
    xlate(16'hE000);
    check("R9 common base kept", 32'(rsp_paddr), 32'h3E000);
    xlate(16'h1000);
    check("R9 boundaries kept", 32'(rsp_area), 32'd0);

    // R10: a write and a request on the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h20;
    req_vld = 1'b1; req_laddr = 16'h2000;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R10 old base used", 32'(rsp_paddr), 32'h12000);
    // Next request (still asserted) sees the new base
    @(negedge clk);
    req_vld = 1'b0;
    check("R10 new base used", 32'(rsp_paddr), 32'h22000);

    // R7: back-to-back requests, one result per cycle
    @(negedge clk);
    req_vld = 1'b1; req_laddr = 16'h0100;
    @(negedge clk);
    check("R7 b2b first", 32'(rsp_paddr), 32'h00100);
    req_laddr = 16'hE010;
    @(negedge clk);
    check("R7 b2b second", 32'(rsp_paddr), 32'h3E010);
    req_vld = 1'b0;
    @(negedge clk);
    check("R7 valid drops", 32'(rsp_vld), 32'd0);

    // R8: payload holds while idle, even with a changing address
    req_laddr = 16'h3333;
    repeat (3) @(negedge clk);
    check("R8 paddr held", 32'(rsp_paddr), 32'h3E010);
    check("R8 area held", 32'(rsp_area), 32'd2);

    done = 1;
    finish_run();
  end

endmodule